// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital sequencer of a successive-approximation converter that sits on a parallel bus. A host writes an 8-bit control word with a one-cycle write strobe. The sequencer decodes the operating mode, the clock source, the acquisition style, the input configuration and the channel number from that word. It then runs the acquisition phase and the conversion phase and latches the finished code. Completion is signalled on an active-low interrupt line, which the host clears with a read strobe.

Two acquisition styles are supported. In the self-timed style a single write opens a fixed sampling window, and the conversion follows it automatically. In the host-timed style one write opens the window and a second write closes it and starts the conversion. If the input configuration changes between those two writes, the sequencer flags the result as corrupt. Any control write aborts a conversion that is in progress.

The analog front end is not part of this block. The converted code arrives on an input bus, and the internal oscillator is represented by a clock-enable input.

Top module: `adc_seq_top`

## Requirements
- R1: Control word fields are decoded as follows.
  - Bits 7:6 select the mode: 00 is full power-down, 01 is standby, 10 is run on the system clock, 11 is run on the oscillator enable.
  - Bit 5 selects host-timed acquisition (1) or self-timed acquisition (0).
  - Bit 4 selects single-ended input.
  - Bit 3 selects unipolar coding.
  - Bits 2:0 give the channel.
  - After a run-mode write that opens an acquisition, `chanSel`, `sglMode` and `uniMode` show bits 2:0, bit 4 and bit 3 of that word from the next cycle on.
- R2: A power-down or standby write leaves `intClkSel` at the clock source given by the last run-mode write.
- R3: A run-mode write with bit 5 clear starts a self-timed acquisition of 3 ticks, followed by a conversion of 13 ticks. `intN` falls on the 16th tick edge after the write edge.
- R4: A run-mode write with bit 5 set holds acquisition open with no completion, however long it lasts. A later run-mode write with bit 5 clear starts a 13-tick conversion, and `intN` falls on the 13th tick edge after that second write.
- R5: On the second write of a host-timed acquisition, bits 4:0 are compared with those of the first write, while bits 7:6 may differ. `corruptFlag` is loaded together with the result: 1 if any compared bit differs, 0 otherwise.
- R6: In oscillator mode (bits 7:6 = 11) a tick is a clock edge with `intClkEn` high. In system-clock mode every clock edge is a tick.
- R7: A control write made while an acquisition or conversion is in progress aborts it. No completion is produced for the aborted operation, and a run-mode write restarts timing from its own edge.
- R8: `intN` returns high on the cycle after a read strobe or a control write.
- R9: Unipolar results are presented unchanged. Bipolar results have bit 9 of the raw code inverted, which gives two's complement.
- R10: After a power-down or standby write, `powerDown` is 1 and the sequencer produces no completion, even if further power-down words are written. `dataOut` keeps the last result until a run-mode write wakes the sequencer.
- R11: After reset, `intN` is 1, `dataOut` is 0, `corruptFlag` is 0, `powerDown` is 0 and `intClkSel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrStrobe | input | 1 | One-cycle control write strobe |
| ctrlByte | input | 8 | Control word, sampled when `wrStrobe` is high |
| rdStrobe | input | 1 | One-cycle result read strobe |
| intClkEn | input | 1 | Oscillator tick enable, used in oscillator mode |
| anaCode | input | 10 | Raw straight-binary code from the analog stub |
| intN | output | 1 | Active-low conversion-complete interrupt |
| dataOut | output | 10 | Latched, coded conversion result |
| corruptFlag | output | 1 | Set when the last host-timed conversion had a configuration mismatch |
| powerDown | output | 1 | High while in full power-down or standby |
| intClkSel | output | 1 | Selected clock source (1 = oscillator) |
| chanSel | output | 3 | Latched channel number |
| sglMode | output | 1 | Latched single-ended selection |
| uniMode | output | 1 | Latched unipolar selection |

## Verification
The bound checker watches the interrupt line on every cycle. It checks that the line falls only on the cycle after a completion strobe, and that a write or read releases it. It also checks that no completion coincides with a write or with power-down, and that `dataOut` moves only on completion. Several behaviours can only be shown by the bench scenarios: the 16-tick and 13-tick latencies under both clock sources, the host-timed window held open indefinitely, the corrupt flag after a changed address, the bipolar recoding, clock-source retention across power-down, and the absence of a result after an abort.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACQI = 3'd1,
    ST_ACQX = 3'd2,
    ST_CONV = 3'd3,
    ST_OFF  = 3'd4
  } seq_state_t;

  // input configuration, laid out as control word bits 4:0
  typedef struct packed {
    logic       sgl;
    logic       uni;
    logic [2:0] chan;
  } in_cfg_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic modeLoad;
    logic cfgLoad;
    logic cfgCompare;
    logic convDone;
    logic intClear;
  } seq_strb_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int ACQ_TICKS  = 3,
  parameter int CONV_TICKS = 13
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wrStrobe,
  input  logic [7:0] ctrlByte,
  input  logic      rdStrobe,
  input  logic      intClkEn,
  input  logic      clkIntMode,
  output seq_strb_t strb,
  output logic      powerDown
);

  localparam int MAX_TICKS = (ACQ_TICKS > CONV_TICKS) ? ACQ_TICKS : CONV_TICKS;
  localparam int CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_TICKS - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_TICKS - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] tickCnt;
  logic             tick;
  logic             runWord;
  logic             hostTimed;

  assign tick      = clkIntMode ? intClkEn : 1'b1;
  assign runWord   = ctrlByte[7];
  assign hostTimed = ctrlByte[5];
  assign powerDown = (state == ST_OFF);

  always_comb begin
    strb = '0;
    if (wrStrobe) begin
      strb.intClear = 1'b1;
      if (runWord) begin
        strb.modeLoad = 1'b1;
        if (!hostTimed && state == ST_ACQX) strb.cfgCompare = 1'b1;
        else                                 strb.cfgLoad    = 1'b1;
      end
    end else begin
      strb.intClear = rdStrobe;
      strb.convDone = (state == ST_CONV) && tick && (tickCnt == CONV_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
    end else if (wrStrobe) begin
      tickCnt <= '0;
      if (!runWord)                   state <= ST_OFF;
      else if (hostTimed)             state <= ST_ACQX;
      else if (state == ST_ACQX)      state <= ST_CONV;
      else                            state <= ST_ACQI;
    end else begin
      unique case (state)
        ST_ACQI: if (tick) begin
          if (tickCnt == ACQ_LAST) begin
            state   <= ST_CONV;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_CONV: if (tick) begin
          if (tickCnt == CONV_LAST) begin
            state   <= ST_IDLE;
            tickCnt <= '0;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: tickCnt <= '0;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_strb_t        strb,
  input  logic [7:0]       ctrlByte,
  input  logic [RES_W-1:0] anaCode,
  output logic             clkIntMode,
  output logic [2:0]       chanSel,
  output logic             sglMode,
  output logic             uniMode,
  output logic [RES_W-1:0] dataOut,
  output logic             corruptFlag,
  output logic             intN
);

  localparam int MSB = RES_W - 1;

  in_cfg_t          cfgReg;
  in_cfg_t          wordCfg;
  logic             pendCorrupt;
  logic [RES_W-1:0] codedResult;

  assign wordCfg = in_cfg_t'(ctrlByte[4:0]);
  assign chanSel = cfgReg.chan;
  assign sglMode = cfgReg.sgl;
  assign uniMode = cfgReg.uni;

  generate
    if (RES_W > 1) begin : g_wide
      assign codedResult = cfgReg.uni ? anaCode : {~anaCode[MSB], anaCode[MSB-1:0]};
    end else begin : g_narrow
      assign codedResult = cfgReg.uni ? anaCode : ~anaCode;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkIntMode  <= 1'b0;
      cfgReg      <= '0;
      pendCorrupt <= 1'b0;
      dataOut     <= '0;
      corruptFlag <= 1'b0;
      intN        <= 1'b1;
    end else begin
      if (strb.modeLoad) clkIntMode <= ctrlByte[6];
      if (strb.cfgLoad) begin
        cfgReg      <= wordCfg;
        pendCorrupt <= 1'b0;
      end else if (strb.cfgCompare) begin
        pendCorrupt <= (wordCfg != cfgReg);
      end
      if (strb.convDone) begin
        dataOut     <= codedResult;
        corruptFlag <= pendCorrupt;
        intN        <= 1'b0;
      end else if (strb.intClear) begin
        intN <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int ACQ_TICKS  = 3,
  parameter int CONV_TICKS = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrStrobe,
  input  logic [7:0]       ctrlByte,
  input  logic             rdStrobe,
  input  logic             intClkEn,
  input  logic [RES_W-1:0] anaCode,
  output logic             intN,
  output logic [RES_W-1:0] dataOut,
  output logic             corruptFlag,
  output logic             powerDown,
  output logic             intClkSel,
  output logic [2:0]       chanSel,
  output logic             sglMode,
  output logic             uniMode
);

  seq_strb_t strb;
  logic      clkIntMode;

  assign intClkSel = clkIntMode;

  adc_seq_ctrl #(
    .ACQ_TICKS (ACQ_TICKS),
    .CONV_TICKS(CONV_TICKS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrStrobe  (wrStrobe),
    .ctrlByte  (ctrlByte),
    .rdStrobe  (rdStrobe),
    .intClkEn  (intClkEn),
    .clkIntMode(clkIntMode),
    .strb      (strb),
    .powerDown (powerDown)
  );

  adc_seq_dp #(
    .RES_W(RES_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .ctrlByte   (ctrlByte),
    .anaCode    (anaCode),
    .clkIntMode (clkIntMode),
    .chanSel    (chanSel),
    .sglMode    (sglMode),
    .uniMode    (uniMode),
    .dataOut    (dataOut),
    .corruptFlag(corruptFlag),
    .intN       (intN)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wrStrobe,
  input logic             rdStrobe,
  input logic             intN,
  input logic             powerDown,
  input seq_strb_t        strb,
  input logic [RES_W-1:0] dataOut
);

  a_r8_write_releases_int: assert property (@(posedge clk) disable iff (!rst_n)
    wrStrobe |=> intN);

  a_r8_read_releases_int: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && !strb.convDone) |=> intN);

  a_r3_done_lowers_int: assert property (@(posedge clk) disable iff (!rst_n)
    strb.convDone |=> !intN);

  a_r3_int_falls_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intN) |-> $past(strb.convDone));

  a_r7_write_blocks_done: assert property (@(posedge clk) disable iff (!rst_n)
    wrStrobe |-> !strb.convDone);

  a_r10_no_done_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    powerDown |-> !strb.convDone);

  a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.convDone |=> $stable(dataOut));

endmodule

bind adc_seq_top adc_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wrStrobe (wrStrobe),
  .rdStrobe (rdStrobe),
  .intN     (intN),
  .powerDown(powerDown),
  .strb     (strb),
  .dataOut  (dataOut)
);

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] ctrlByte = 8'h00;
  logic       rdStrobe = 1'b0;
  logic       intClkEn = 1'b0;
  logic [9:0] anaCode = 10'h000;
  logic       intN;
  logic [9:0] dataOut;
  logic       corruptFlag;
  logic       powerDown;
  logic       intClkSel;
  logic [2:0] chanSel;
  logic       sglMode;
  logic       uniMode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastWr = 0;
  bit intModeTb = 1'b0;
  bit prevInt = 1'b1;

  // scoreboard: expected result, corrupt flag, completion edge, requirement tag
  logic [9:0] expData[$];
  logic       expCorr[$];
  int         expCyc[$];
  string      expTag[$];

  adc_seq_top dut (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .ctrlByte(ctrlByte),
    .rdStrobe(rdStrobe), .intClkEn(intClkEn), .anaCode(anaCode),
    .intN(intN), .dataOut(dataOut), .corruptFlag(corruptFlag),
    .powerDown(powerDown), .intClkSel(intClkSel), .chanSel(chanSel),
    .sglMode(sglMode), .uniMode(uniMode)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // oscillator stub: enable high on every 4th edge
  always @(negedge clk) intClkEn <= (cyc % 4 == 0);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: every falling interrupt must match the head of the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (prevInt && !intN) begin
        if (expData.size() == 0) begin
          chk(1'b0, "R7 unexpected completion", int'(dataOut), -1);
        end else begin
          chk(dataOut == expData[0], {expTag[0], " data"}, int'(dataOut), int'(expData[0]));
          chk(corruptFlag == expCorr[0], {"R5 corrupt ", expTag[0]}, int'(corruptFlag), int'(expCorr[0]));
          chk(cyc == expCyc[0], {expTag[0], " latency"}, cyc, expCyc[0]);
          void'(expData.pop_front());
          void'(expCorr.pop_front());
          void'(expCyc.pop_front());
          void'(expTag.pop_front());
        end
      end
      prevInt = intN;
    end
  end

  task automatic wrByte(input logic [7:0] b);
    @(negedge clk);
    ctrlByte = b;
    wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
    lastWr = cyc;
    if (b[7]) intModeTb = b[6];
  endtask

  task automatic rdPulse();
    @(negedge clk);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 0;
  endtask

  // push an expectation that completes after nTicks ticks counted from the last write edge
  task automatic expectDone(input logic [9:0] d, input logic c, input int nTicks, input string tag);
    int n = lastWr;
    int got = 0;
    while (got < nTicks) begin
      n++;
      if (!intModeTb || ((n - 1) % 4 == 0)) got++;
    end
    expData.push_back(d);
    expCorr.push_back(c);
    expCyc.push_back(n);
    expTag.push_back(tag);
  endtask

  task automatic waitDrain(input string tag);
    int t = 0;
    while (expData.size() != 0 && t < 600) begin
      @(negedge clk);
      t++;
    end
    chk(expData.size() == 0, {tag, " completion seen"}, expData.size(), 0);
  endtask

  initial begin
    #(4ns * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(intN == 1'b1, "R11 intN", int'(intN), 1);
    chk(dataOut == 10'h0, "R11 dataOut", int'(dataOut), 0);
    chk(corruptFlag == 1'b0, "R11 corruptFlag", int'(corruptFlag), 0);
    chk(powerDown == 1'b0, "R11 powerDown", int'(powerDown), 0);
    chk(intClkSel == 1'b0, "R11 intClkSel", int'(intClkSel), 0);

    // R1 R3: self-timed, system clock, single-ended unipolar channel 5
    anaCode = 10'h2A5;
    wrByte(8'h9D);
    expectDone(10'h2A5, 1'b0, 16, "R3");
    chk(chanSel == 3'd5, "R1 chanSel", int'(chanSel), 5);
    chk(sglMode == 1'b1, "R1 sglMode", int'(sglMode), 1);
    chk(uniMode == 1'b1, "R1 uniMode", int'(uniMode), 1);
    waitDrain("R3");
    rdPulse();
    chk(intN == 1'b1, "R8 read clears", int'(intN), 1);

    // R9: bipolar, channel 2, differential
    wrByte(8'h82);
    expectDone(10'h0A5, 1'b0, 16, "R9");
    chk(uniMode == 1'b0 && sglMode == 1'b0 && chanSel == 3'd2, "R1 bipolar cfg",
        int'({sglMode, uniMode, chanSel}), 2);
    waitDrain("R9");

    // R4: host-timed window open, write also clears interrupt (R8)
    wrByte(8'hBB);
    chk(intN == 1'b1, "R8 write clears", int'(intN), 1);
    repeat (60) @(negedge clk);
    chk(intN == 1'b1, "R4 window held open", int'(intN), 1);
    // R5 R6: close with PD bits changed to oscillator mode, same config
    anaCode = 10'h3FF;
    wrByte(8'hDB);
    expectDone(10'h3FF, 1'b0, 13, "R4 R6");
    chk(intClkSel == 1'b1, "R6 intClkSel", int'(intClkSel), 1);
    waitDrain("R4 R6");

    // R5: address changed on the closing write
    anaCode = 10'h155;
    wrByte(8'hBB);
    repeat (5) @(negedge clk);
    wrByte(8'h9A);
    expectDone(10'h155, 1'b1, 13, "R5");
    waitDrain("R5");

    // R7: abort a running conversion with a new word
    wrByte(8'h9D);
    repeat (10) @(negedge clk);
    anaCode = 10'h300;
    wrByte(8'h85);
    expectDone(10'h100, 1'b0, 16, "R7 R9");
    waitDrain("R7");
    repeat (30) @(negedge clk);

    // R2 R10: oscillator mode conversion then power-down
    anaCode = 10'h0F0;
    wrByte(8'hD9);
    expectDone(10'h0F0, 1'b0, 16, "R6");
    waitDrain("R6");
    wrByte(8'h00);
    chk(powerDown == 1'b1, "R10 powerDown", int'(powerDown), 1);
    chk(intClkSel == 1'b1, "R2 clock kept full", int'(intClkSel), 1);
    anaCode = 10'h111;
    wrByte(8'h5D);
    chk(intClkSel == 1'b1, "R2 clock kept standby", int'(intClkSel), 1);
    repeat (80) @(negedge clk);
    chk(dataOut == 10'h0F0, "R10 result kept", int'(dataOut), 'h0F0);
    chk(powerDown == 1'b1 && intN == 1'b1, "R10 still idle", int'({powerDown, intN}), 3);

    // wake
    anaCode = 10'h200;
    wrByte(8'h9D);
    chk(powerDown == 1'b0, "R10 wake", int'(powerDown), 0);
    chk(intClkSel == 1'b0, "R2 new clock", int'(intClkSel), 0);
    expectDone(10'h200, 1'b0, 16, "R10 wake");
    waitDrain("R10");

    // R7 R10: power-down word aborts a conversion
    wrByte(8'h9D);
    repeat (8) @(negedge clk);
    wrByte(8'h40);
    repeat (40) @(negedge clk);
    chk(dataOut == 10'h200, "R7 abort kept result", int'(dataOut), 'h200);
    chk(powerDown == 1'b1, "R10 off after abort", int'(powerDown), 1);

    // R9: bipolar zero code
    anaCode = 10'h000;
    wrByte(8'h82);
    expectDone(10'h200, 1'b0, 16, "R9 zero");
    waitDrain("R9 zero");
    rdPulse();
    chk(intN == 1'b1, "R8 final read", int'(intN), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule